// File: doc/BRIEF.md
# Complementary Dead-Band Generator

This block turns one PWM phase signal into a complementary pair of gate-drive outputs for the upper and lower switch of a half bridge. The high-side output follows the phase and the low-side output follows its inverse. Every turn-on is held back by a programmable dead time, so the two switches are never driven together. Turn-off is never delayed.

The dead time is a 4-bit period count multiplied by a power-of-two prescale factor, in cycles of the block clock. Each change of the phase input clears the prescaler and restarts the period counter. The delay is therefore always measured from the phase edge, whatever phase the counters were in. With insertion switched off, or with a period of zero, the block passes the phase and its inverse straight through its output registers.

Top module: `deadband_pair`

## Requirements
- R1: `gate_hi` and `gate_lo` are never high in the same cycle.
- R2: With insertion active (`db_enable`=1 and `db_period`≠0), the clock edge that first samples a changed `phase_in` drives both outputs low.
- R3: With insertion active, after a phase edge sampled at clock edge k, the output for the new phase level (`gate_hi` for 1, `gate_lo` for 0) goes high at edge k + P·D and not earlier. P is `db_period` and D is the prescale factor.
- R4: The prescale factor D is picked by `db_prescale`: 0→1, 1→2, 2→4, 3→8, 4→16, and 5, 6 and 7 all give 32.
- R5: With `db_enable`=0, each clock edge loads `gate_hi` with `phase_in` and `gate_lo` with its inverse. There is one cycle of latency and no dead time.
- R6: With `db_enable`=1 and `db_period`=0, the outputs behave exactly as in R5.
- R7: A phase pulse shorter than P·D cycles never turns on its output. The next edge restarts the delay for the opposite output.
- R8: During synchronous reset both outputs are low and the stored phase reference is 0.
- R9: The dead time is the same whatever the cycle offset of the phase edge, because the prescaler is cleared by that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_in | input | 1 | PWM phase to be split |
| db_period | input | 4 | Dead-time count P in prescaled ticks |
| db_prescale | input | 3 | Prescale select, see R4 |
| db_enable | input | 1 | 1 inserts dead time, 0 passes through |
| gate_hi | output | 1 | High-side drive, follows phase |
| gate_lo | output | 1 | Low-side drive, follows inverted phase |

## Verification
The assertions assume that `db_period` and `db_prescale` change only while no delay is running. One check ties the end of a delay to a prescaler tick, and it allows an abort or a restart. The random stimulus keeps to this assumption: the configuration changes only after the phase has been held for 500 cycles, which is longer than the largest dead time of 480 cycles. Phase run lengths mix pulses shorter than the dead time with longer ones, so that restarts and suppressed pulses both occur.

// File: rtl/dbgen_pkg.sv
package dbgen_pkg;
  localparam int SEL_W     = 3;
  localparam int CNT_W     = 4;
  localparam int MAX_SHIFT = 5;
  localparam int PRE_W     = MAX_SHIFT;

  // last count value of the prescaler for a select code (divide minus one)
  function automatic logic [PRE_W-1:0] div_last(input logic [SEL_W-1:0] sel);
    int sh;
    sh = (int'(sel) > MAX_SHIFT) ? MAX_SHIFT : int'(sel);
    return PRE_W'((1 << sh) - 1);
  endfunction
endpackage

// File: rtl/dbp_edge.sv
module dbp_edge (
  input  logic clk,
  input  logic rst,
  input  logic phase_in,
  output logic phase_q,
  output logic edge_seen
);
  always_ff @(posedge clk) begin
    if (rst) phase_q <= 1'b0;
    else     phase_q <= phase_in;
  end

  assign edge_seen = phase_in ^ phase_q;

  a_r8_ref_cleared: assert property (@(posedge clk)
    $past(rst) |-> !phase_q);
endmodule

// File: rtl/dbp_prescaler.sv
module dbp_prescaler
  import dbgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] last;

  assign last = div_last(sel);
  assign tick = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt <= '0;
    else if (run)      cnt <= tick ? '0 : cnt + 1'b1;
  end

  // R9: right after a clear only divide-by-one may tick
  a_r9_clear_restarts: assert property (@(posedge clk) disable iff (rst)
    clear && $stable(sel) |=> (!tick || div_last(sel) == '0));
endmodule

// File: rtl/dbp_counter.sv
module dbp_counter
  import dbgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             abort,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   nxt;

  assign nxt  = {1'b0, cnt} + 1'b1;
  assign done = busy && tick && (nxt >= {1'b0, period});

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy && tick) begin
      cnt <= nxt[CNT_W-1:0];
      if (done) busy <= 1'b0;
    end
  end

  // R3: a delay ends only on a prescaler tick, unless aborted or restarted
  a_r3_ends_on_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) && !$past(abort) && !$past(start) && !$past(rst) |-> $past(tick));
endmodule

// File: rtl/deadband_pair.sv
module deadband_pair
  import dbgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             phase_in,
  input  logic [CNT_W-1:0] db_period,
  input  logic [SEL_W-1:0] db_prescale,
  input  logic             db_enable,
  output logic             gate_hi,
  output logic             gate_lo
);
  logic phase_q, edge_seen, bypass, start, tick, busy, done;

  assign bypass = !db_enable || (db_period == '0);
  assign start  = edge_seen && !bypass;

  dbp_edge u_edge (
    .clk(clk), .rst(rst), .phase_in(phase_in),
    .phase_q(phase_q), .edge_seen(edge_seen)
  );

  dbp_prescaler u_pre (
    .clk(clk), .rst(rst), .clear(start), .run(busy),
    .sel(db_prescale), .tick(tick)
  );

  dbp_counter u_cnt (
    .clk(clk), .rst(rst), .start(start), .abort(bypass),
    .tick(tick), .period(db_period), .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else if (bypass) begin
      gate_hi <= phase_in;
      gate_lo <= !phase_in;
    end else if (edge_seen) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else if (!busy || done) begin
      gate_hi <= phase_q;
      gate_lo <= !phase_q;
    end
  end

  a_r1_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(gate_hi && gate_lo));

  a_r2_edge_blanks: assert property (@(posedge clk) disable iff (rst)
    edge_seen && !bypass |=> !gate_hi && !gate_lo);

  a_r5_bypass_follow: assert property (@(posedge clk) disable iff (rst)
    bypass |=> (gate_hi == $past(phase_in)) && (gate_lo == !$past(phase_in)));

  a_r3_rise_needs_done: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_hi) && !$past(bypass) && !$past(rst) |-> $past(done));
endmodule

// File: tb/deadband_pair_test.sv
module deadband_pair_test;
  localparam int CLK_P = 10;
  localparam int BIG   = 100000;

  logic clk = 0, rst = 1, ph = 0, en = 0;
  logic [3:0] per = 0;
  logic [2:0] sel = 0;
  logic gate_hi, gate_lo;

  int errors = 0, checks = 0, cycles = 0;
  logic m_ph = 0;
  int since = BIG;
  bit done_flag = 0;

  deadband_pair uut (
    .clk(clk), .rst(rst), .phase_in(ph), .db_period(per),
    .db_prescale(sel), .db_enable(en), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int divf(input logic [2:0] s);
    return (s >= 5) ? 32 : (1 << s);
  endfunction

  task automatic report_sum();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !done_flag) begin
        errors++; checks++;
        $display("FAIL watchdog: cycles=%0d expected below 190000", cycles);
        report_sum();
        $finish;
      end
    end
  end

  task automatic chk(input string tag, input logic a, input logic e, input string what);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b (cycle %0d)", tag, what, a, e, cycles);
    end
  endtask

  // one clock: reference model at the edge, compare shortly after it
  task automatic cyc();
    logic eh, el;
    string tag;
    @(posedge clk);
    if (rst) begin
      m_ph = 0; since = BIG; eh = 0; el = 0; tag = "R8";
    end else begin
      if (ph != m_ph) since = 0;
      else if (since < BIG) since++;
      m_ph = ph;
      if (!en)           begin eh = ph; el = !ph; tag = "R5"; end
      else if (per == 0) begin eh = ph; el = !ph; tag = "R6"; end
      else if (since >= int'(per) * divf(sel)) begin eh = ph; el = !ph; tag = "R3"; end
      else begin eh = 0; el = 0; tag = "R2"; end
    end
    #1;
    chk(tag, gate_hi, eh, "gate_hi");
    chk(tag, gate_lo, el, "gate_lo");
    checks++;
    if (gate_hi && gate_lo) begin
      errors++;
      $display("FAIL R1 overlap: actual=11 expected=not both (cycle %0d)", cycles);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  // apply rising phase edge and count cycles until gate_hi goes high
  task automatic measure(input string tag, input int expect_n);
    int n;
    ph = 1; n = 0;
    cyc();
    while (!gate_hi && n < 600) begin n++; cyc(); end
    checks++;
    if (n != expect_n) begin
      errors++;
      $display("FAIL %s delay: actual=%0d expected=%0d", tag, n, expect_n);
    end
    run(5);
    ph = 0; run(500);
  endtask

  initial begin
    int seed;
    bit hi_seen;
    seed = 32'h5eed_0d1b;
    void'($urandom(seed));

    // R8 reset state
    run(3);
    chk("R8", gate_hi, 1'b0, "gate_hi in reset");
    chk("R8", gate_lo, 1'b0, "gate_lo in reset");
    rst = 0;
    run(3);
    chk("R8", gate_lo, 1'b1, "gate_lo after reset, phase 0");

    // R4 each prescale code with P=3
    en = 1; per = 3;
    for (int c = 0; c < 8; c++) begin
      sel = 3'(c); run(500);
      measure("R4", 3 * ((c >= 5) ? 32 : (1 << c)));
    end

    // R9 edge at varied offsets within the divide-by-32 period
    sel = 7; per = 2;
    for (int off = 0; off < 6; off++) begin
      run(off * 7 + 1);
      measure("R9", 64);
    end

    // R7 short pulse suppressed, opposite side delayed by full time
    sel = 0; per = 10; run(20);
    ph = 1; hi_seen = 0;
    for (int i = 0; i < 5; i++) begin cyc(); if (gate_hi) hi_seen = 1; end
    ph = 0;
    for (int i = 0; i < 30; i++) begin cyc(); if (gate_hi) hi_seen = 1; end
    chk("R7", hi_seen, 1'b0, "gate_hi during short pulse");

    // R6 period zero and R5 disabled: no dead time
    per = 0; run(5); ph = 1; cyc();
    chk("R6", gate_hi, 1'b1, "gate_hi immediate with period 0");
    en = 0; per = 9; run(3); ph = 0; cyc();
    chk("R5", gate_lo, 1'b1, "gate_lo immediate when disabled");
    run(500);

    // constrained random segments
    for (int s = 0; s < 40; s++) begin
      int left, len, dt;
      en  = ($urandom_range(9) != 0);
      per = 4'($urandom_range(15));
      sel = 3'($urandom_range(7));
      dt  = int'(per) * divf(sel);
      left = 1000;
      while (left > 0) begin
        if ($urandom_range(1)) len = $urandom_range(dt + 2, 1);
        else                   len = $urandom_range(dt + 40, dt + 1);
        ph = !ph;
        run(len);
        left -= len;
      end
      run(500);
    end

    done_flag = 1;
    report_sum();
    $finish;
  end
endmodule